// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar date as packed BCD in a chain of counters. A sub-second counter advances on each pulse of the `tick` input. When it overflows it steps the seconds. The carry then ripples through minutes, hours, weekday, day of month, month and a four-digit year. Day-of-month wrapping follows the length of the current month, including Gregorian leap years.

Software reaches the block through one register port with byte enables. Registers sit at a 2-byte stride and are selected by `addr[4:1]`, so `addr[0]` is ignored. To set the time, software first writes the second control register with run cleared and the prescaler-clear bit set. It then loads the BCD fields and finally sets the enable and run bits. A carry flag records every counter carry, so software can clear it, read the fields, and retry if the flag came back set. The carry flag, gated by its enable, drives the carry interrupt. A round-to-minute command snaps the seconds to 00.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset, the fields read: seconds 00, minutes 00, hours 00, weekday 0, day 01, month 01, year 0x2000. The sub-second count, both control registers and `carry_irq` are 0.
- R2: Register index `addr[4:1]` selects the register: 0 sub-second count (read only), 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, 7 year (century in bits 15:8, year-in-century in bits 7:0), 14 control 1, 15 control 2. A write with `be[0]` loads the low byte of the selected register, and a read returns the stored value.
- R3: The 7-bit sub-second count increments on each `tick` only while run (control 2 bit 0) is 1. When it passes 127 it wraps to 0 and steps the seconds by one.
- R4: Seconds and minutes wrap from 0x59 to 0x00 and carry on. Hours wrap from 0x23 to 0x00 and step both weekday and day. Weekday wraps from 6 to 0.
- R5: Day wraps to 01 after 0x28, 0x29, 0x30 or 0x31, depending on the month. February has 29 days when the year-in-century is a nonzero multiple of 4, or when it is 00 and the century is a multiple of 4. Month wraps from 0x12 to 0x01 and then steps the year in BCD.
- R6: The carry flag (control 1 bit 7) is set by every sub-second carry into seconds and by every round-to-minute command. Writing 0 to that bit clears it, and writing 1 leaves it unchanged. A set in the same cycle as a clear wins.
- R7: `carry_irq` is 1 exactly while the carry flag and the carry interrupt enable (control 1 bit 4) are both 1.
- R8: Writing control 2 with bit 2 set clears the seconds to 00. If the seconds were 0x30 or more, the same write also steps the minutes, and that step carries on. Bit 2 always reads back as 0.
- R9: Writing control 2 with bit 1 set clears the sub-second count. Bit 1 then reads 1 for one cycle and 0 afterwards. Control 2 bit 3 (enable) and bit 0 (run) are stored from the written byte.
- R10: A write to the year register with `be[1]` only changes bits 15:8, and a write with `be[0]` only changes bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sub-second count pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address; bits 4:1 select the register |
| be | input | 2 | Byte enables for `wdata` |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register (combinational) |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The counter chain is tested by loading boundary times and then applying exactly 128 ticks. One of these is 23:59:59 on 31 December 2099, which has to ripple through every field into the century. Single February 28/29 roll-overs are run in the years 2023, 2024, 2000 and 2100, which separate the leap rule for the year-in-century from the rule for the century. A 30-day month and a 31-day month show that the day limit follows the month. Tick bursts with run cleared, the round-to-minute command with seconds at 29, 30 and 45, and byte-lane writes to the year each isolate one control path from the counting path.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int REG_IDX_W = 4;

  localparam logic [REG_IDX_W-1:0] IDX_SUB  = 4'd0;
  localparam logic [REG_IDX_W-1:0] IDX_SEC  = 4'd1;
  localparam logic [REG_IDX_W-1:0] IDX_MIN  = 4'd2;
  localparam logic [REG_IDX_W-1:0] IDX_HOUR = 4'd3;
  localparam logic [REG_IDX_W-1:0] IDX_WDAY = 4'd4;
  localparam logic [REG_IDX_W-1:0] IDX_MDAY = 4'd5;
  localparam logic [REG_IDX_W-1:0] IDX_MON  = 4'd6;
  localparam logic [REG_IDX_W-1:0] IDX_YEAR = 4'd7;
  localparam logic [REG_IDX_W-1:0] IDX_CTL1 = 4'd14;
  localparam logic [REG_IDX_W-1:0] IDX_CTL2 = 4'd15;

  // control register 1 bits
  localparam int CF_BIT  = 7;
  localparam int CIE_BIT = 4;
  // control register 2 bits
  localparam int EN_BIT    = 3;
  localparam int ADJ_BIT   = 2;
  localparam int CLR_BIT   = 1;
  localparam int START_BIT = 0;

  // one BCD digit plus one: {carry_out, digit}
  function automatic logic [4:0] bcd_digit_inc(input logic [3:0] d);
    if (d >= 4'd9) return {1'b1, 4'h0};
    return {1'b0, d + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
    return ({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
  endfunction

  // Gregorian leap rule on a four-digit BCD year
  function automatic logic is_leap(input logic [15:0] yr);
    logic [6:0] yy;
    logic [6:0] cc;
    yy = bcd_to_bin(yr[7:0]);
    cc = bcd_to_bin(yr[15:8]);
    if (yy != 7'd0) return (yy % 7'd4) == 7'd0;
    return (cc % 7'd4) == 7'd0;
  endfunction

  // last day of the month, in BCD
  function automatic logic [7:0] month_len(input logic [7:0] mon,
                                           input logic [15:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field import rtc_pkg::*; #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   FLOOR   = '0,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] limit,
  output logic [W-1:0] val,
  output logic         wrap
);

  localparam int DIGITS = W / 4;

  logic [W-1:0] inc_val;

  always_comb begin
    logic c;
    logic [4:0] r;
    inc_val = val;
    c = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      r = bcd_digit_inc(val[i*4 +: 4]);
      if (c) inc_val[i*4 +: 4] = r[3:0];
      c = c & r[4];
    end
  end

  assign wrap = step & ~ld & (val == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    val <= RST_VAL;
    else if (ld)   val <= ld_val;
    else if (step) val <= (val == limit) ? FLOOR : inc_val;
  end

endmodule

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int SUB_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  output logic [SUB_W-1:0] cnt,
  output logic             carry
);

  assign carry = run & tick & ~clr & (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (run && tick) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl import rtc_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl1_wr,
  input  logic       ctl2_wr,
  input  logic [7:0] wbyte,
  input  logic       carry_evt,
  output logic       cf,
  output logic       cie,
  output logic       en,
  output logic       run,
  output logic       clr_flag,
  output logic       adj_req,
  output logic       pre_clr,
  output logic       irq
);

  logic wbyte_unused;
  assign wbyte_unused = ^wbyte[6:5];

  assign adj_req = ctl2_wr & wbyte[ADJ_BIT];
  assign pre_clr = ctl2_wr & wbyte[CLR_BIT];
  assign irq     = cf & cie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cf       <= 1'b0;
      cie      <= 1'b0;
      en       <= 1'b0;
      run      <= 1'b0;
      clr_flag <= 1'b0;
    end else begin
      if (carry_evt)                     cf <= 1'b1;
      else if (ctl1_wr && !wbyte[CF_BIT]) cf <= 1'b0;
      if (ctl1_wr) cie <= wbyte[CIE_BIT];
      if (ctl2_wr) begin
        en  <= wbyte[EN_BIT];
        run <= wbyte[START_BIT];
      end
      clr_flag <= pre_clr;
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar import rtc_pkg::*; #(
  parameter logic [15:0] RESET_YEAR = 16'h2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_step,
  input  logic        adj_req,
  input  logic [6:0]  fld_ld,
  input  logic [15:0] ld_data,
  output logic [7:0]  sec,
  output logic [7:0]  min,
  output logic [7:0]  hour,
  output logic [7:0]  wday,
  output logic [7:0]  mday,
  output logic [7:0]  mon,
  output logic [15:0] year,
  output logic        sec_wrap
);

  logic       adj_round;
  logic       sec_inc, sec_ld, min_inc;
  logic [7:0] sec_ldv, mday_lim;
  logic       min_wrap, hour_wrap, mday_wrap, mon_wrap;
  logic       wday_wrap_unused, year_wrap_unused;

  assign adj_round = adj_req & (sec >= 8'h30);
  assign sec_inc   = sec_step & ~adj_req;
  assign sec_ld    = fld_ld[0] | adj_req;
  assign sec_ldv   = adj_req ? 8'h00 : ld_data[7:0];
  assign min_inc   = sec_wrap | adj_round;
  assign mday_lim  = month_len(mon, year);

  rtc_bcd_field #(.W(8), .FLOOR(8'h00), .RST_VAL(8'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .step(sec_inc), .ld(sec_ld), .ld_val(sec_ldv),
    .limit(8'h59), .val(sec), .wrap(sec_wrap));

  rtc_bcd_field #(.W(8), .FLOOR(8'h00), .RST_VAL(8'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .step(min_inc), .ld(fld_ld[1]), .ld_val(ld_data[7:0]),
    .limit(8'h59), .val(min), .wrap(min_wrap));

  rtc_bcd_field #(.W(8), .FLOOR(8'h00), .RST_VAL(8'h00)) u_hour (
    .clk(clk), .rst_n(rst_n), .step(min_wrap), .ld(fld_ld[2]), .ld_val(ld_data[7:0]),
    .limit(8'h23), .val(hour), .wrap(hour_wrap));

  rtc_bcd_field #(.W(8), .FLOOR(8'h00), .RST_VAL(8'h00)) u_wday (
    .clk(clk), .rst_n(rst_n), .step(hour_wrap), .ld(fld_ld[3]), .ld_val(ld_data[7:0]),
    .limit(8'h06), .val(wday), .wrap(wday_wrap_unused));

  rtc_bcd_field #(.W(8), .FLOOR(8'h01), .RST_VAL(8'h01)) u_mday (
    .clk(clk), .rst_n(rst_n), .step(hour_wrap), .ld(fld_ld[4]), .ld_val(ld_data[7:0]),
    .limit(mday_lim), .val(mday), .wrap(mday_wrap));

  rtc_bcd_field #(.W(8), .FLOOR(8'h01), .RST_VAL(8'h01)) u_mon (
    .clk(clk), .rst_n(rst_n), .step(mday_wrap), .ld(fld_ld[5]), .ld_val(ld_data[7:0]),
    .limit(8'h12), .val(mon), .wrap(mon_wrap));

  rtc_bcd_field #(.W(16), .FLOOR(16'h0000), .RST_VAL(RESET_YEAR)) u_year (
    .clk(clk), .rst_n(rst_n), .step(mon_wrap), .ld(fld_ld[6]), .ld_val(ld_data),
    .limit(16'h9999), .val(year), .wrap(year_wrap_unused));

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc import rtc_pkg::*; #(
  parameter int          SUB_W      = 7,
  parameter logic [15:0] RESET_YEAR = 16'h2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 wr_en,
  input  logic [REG_IDX_W:0]   addr,
  input  logic [1:0]           be,
  input  logic [15:0]          wdata,
  output logic [15:0]          rdata,
  output logic                 carry_irq
);

  logic [REG_IDX_W-1:0] idx;
  logic                 addr_lsb_unused;
  logic                 wr_lo, wr_any, ctl1_wr, ctl2_wr;
  logic [6:0]           fld_ld;
  logic [15:0]          ld_data;

  logic [SUB_W-1:0]     subsec;
  logic [15:0]          subsec_view;
  logic                 sec_step, sec_wrap, carry_evt;
  logic                 cf, cie, en, run, clr_flag, adj_req, pre_clr;
  logic [7:0]           sec, min, hour, wday, mday, mon;
  logic [15:0]          year;

  assign idx             = addr[REG_IDX_W:1];
  assign addr_lsb_unused = addr[0];
  assign wr_lo           = wr_en & be[0];
  assign wr_any          = wr_en & (|be);
  assign ctl1_wr         = wr_lo & (idx == IDX_CTL1);
  assign ctl2_wr         = wr_lo & (idx == IDX_CTL2);

  assign fld_ld[0] = wr_lo  & (idx == IDX_SEC);
  assign fld_ld[1] = wr_lo  & (idx == IDX_MIN);
  assign fld_ld[2] = wr_lo  & (idx == IDX_HOUR);
  assign fld_ld[3] = wr_lo  & (idx == IDX_WDAY);
  assign fld_ld[4] = wr_lo  & (idx == IDX_MDAY);
  assign fld_ld[5] = wr_lo  & (idx == IDX_MON);
  assign fld_ld[6] = wr_any & (idx == IDX_YEAR);

  // byte-lane merge, used by the year; byte fields take the low lane
  assign ld_data = {be[1] ? wdata[15:8] : year[15:8],
                    be[0] ? wdata[7:0]  : year[7:0]};

  assign carry_evt   = sec_step | adj_req;
  assign subsec_view = 16'(subsec);

  rtc_subsec #(.SUB_W(SUB_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .clr(pre_clr),
    .cnt(subsec), .carry(sec_step));

  rtc_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl1_wr(ctl1_wr), .ctl2_wr(ctl2_wr),
    .wbyte(wdata[7:0]), .carry_evt(carry_evt), .cf(cf), .cie(cie), .en(en),
    .run(run), .clr_flag(clr_flag), .adj_req(adj_req), .pre_clr(pre_clr),
    .irq(carry_irq));

  rtc_calendar #(.RESET_YEAR(RESET_YEAR)) u_cal (
    .clk(clk), .rst_n(rst_n), .sec_step(sec_step), .adj_req(adj_req),
    .fld_ld(fld_ld), .ld_data(ld_data), .sec(sec), .min(min), .hour(hour),
    .wday(wday), .mday(mday), .mon(mon), .year(year), .sec_wrap(sec_wrap));

  always_comb begin
    rdata = 16'h0000;
    case (idx)
      IDX_SUB:  rdata = subsec_view;
      IDX_SEC:  rdata = {8'h00, sec};
      IDX_MIN:  rdata = {8'h00, min};
      IDX_HOUR: rdata = {8'h00, hour};
      IDX_WDAY: rdata = {8'h00, wday};
      IDX_MDAY: rdata = {8'h00, mday};
      IDX_MON:  rdata = {8'h00, mon};
      IDX_YEAR: rdata = year;
      IDX_CTL1: begin
        rdata[CF_BIT]  = cf;
        rdata[CIE_BIT] = cie;
      end
      IDX_CTL2: begin
        rdata[EN_BIT]    = en;
        rdata[CLR_BIT]   = clr_flag;
        rdata[START_BIT] = run;
      end
      default:  rdata = 16'h0000;
    endcase
  end

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sec_step,
  input logic        sec_wrap,
  input logic        adj_req,
  input logic        pre_clr,
  input logic        ctl1_wr,
  input logic        run,
  input logic        cie,
  input logic        cf,
  input logic        irq,
  input logic        clr_flag,
  input logic [7:0]  sec,
  input logic [15:0] subsec_view
);

  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pre_clr) |=> $stable(subsec_view));

  assert_subsec_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |=> (subsec_view == 16'h0000));

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> (sec == 8'h00));

  assert_flag_on_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |=> cf);

  assert_irq_on_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && cie && !ctl1_wr) |=> irq);

  assert_round_clears_sec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adj_req |=> (sec == 8'h00));

  assert_clear_subsec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pre_clr |=> ((subsec_view == 16'h0000) && clr_flag));

  assert_clear_flag_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !pre_clr) |=> !clr_flag);

endmodule

bind bcd_calendar_rtc rtc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sec_step(sec_step), .sec_wrap(sec_wrap),
  .adj_req(adj_req), .pre_clr(pre_clr), .ctl1_wr(ctl1_wr), .run(run),
  .cie(cie), .cf(cf), .irq(carry_irq), .clr_flag(clr_flag), .sec(sec),
  .subsec_view(subsec_view));

// File: tb/sim_bcd_calendar_rtc.sv
module sim_bcd_calendar_rtc;

  localparam int R_SUB = 0, R_SEC = 1, R_MIN = 2, R_HOUR = 3, R_WDAY = 4;
  localparam int R_DAY = 5, R_MON = 6, R_YEAR = 7, R_C1 = 14, R_C2 = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        carry_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bcd_calendar_rtc u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .be(be), .wdata(wdata), .rdata(rdata), .carry_irq(carry_irq));

  task automatic wr(input int idx, input logic [15:0] d, input logic [1:0] b);
    addr  = 5'(idx * 2);
    wdata = d;
    be    = b;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    be    = 2'b00;
  endtask

  task automatic chk(input int idx, input logic [15:0] exp, input string req);
    addr = 5'(idx * 2);
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s reg%0d got %h expected %h", req, idx, rdata, exp);
    end
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic exp, input string req);
    n_chk++;
    if (carry_irq !== exp) begin
      n_fail++;
      $display("FAIL %s carry_irq got %b expected %b", req, carry_irq, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] h, input logic [7:0] w,
                          input logic [7:0] d, input logic [7:0] mo,
                          input logic [15:0] y);
    wr(R_C2, 16'h0002, 2'b01);
    wr(R_SEC, {8'h00, s}, 2'b01);
    wr(R_MIN, {8'h00, m}, 2'b01);
    wr(R_HOUR, {8'h00, h}, 2'b01);
    wr(R_WDAY, {8'h00, w}, 2'b01);
    wr(R_DAY, {8'h00, d}, 2'b01);
    wr(R_MON, {8'h00, mo}, 2'b01);
    wr(R_YEAR, y, 2'b11);
    wr(R_C2, 16'h0009, 2'b01);
  endtask

  task automatic t_reset();
    chk(R_SUB, 16'h0000, "R1 subsec");
    chk(R_SEC, 16'h0000, "R1 sec");
    chk(R_MIN, 16'h0000, "R1 min");
    chk(R_HOUR, 16'h0000, "R1 hour");
    chk(R_WDAY, 16'h0000, "R1 wday");
    chk(R_DAY, 16'h0001, "R1 day");
    chk(R_MON, 16'h0001, "R1 mon");
    chk(R_YEAR, 16'h2000, "R1 year");
    chk(R_C1, 16'h0000, "R1 ctl1");
    chk(R_C2, 16'h0000, "R1 ctl2");
    chk_irq(1'b0, "R1 irq");
  endtask

  task automatic t_load();
    set_time(8'h12, 8'h34, 8'h05, 8'h03, 8'h17, 8'h08, 16'h2024);
    chk(R_SEC, 16'h0012, "R2 sec");
    chk(R_MIN, 16'h0034, "R2 min");
    chk(R_HOUR, 16'h0005, "R2 hour");
    chk(R_WDAY, 16'h0003, "R2 wday");
    chk(R_DAY, 16'h0017, "R2 day");
    chk(R_MON, 16'h0008, "R2 mon");
    chk(R_YEAR, 16'h2024, "R2 year");
    chk(R_C2, 16'h0009, "R9 ctl2 en/run");
    wr(R_YEAR, 16'h19AB, 2'b10);
    chk(R_YEAR, 16'h1924, "R10 high lane only");
    wr(R_YEAR, 16'hCD33, 2'b01);
    chk(R_YEAR, 16'h1933, "R10 low lane only");
  endtask

  task automatic t_subsec();
    set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 16'h2024);
    ticks(5);
    chk(R_SUB, 16'h0005, "R3 counts ticks");
    wr(R_C2, 16'h0008, 2'b01);
    ticks(10);
    chk(R_SUB, 16'h0005, "R3 stopped holds");
    chk(R_SEC, 16'h0000, "R3 stopped sec");
    wr(R_C2, 16'h000B, 2'b01);
    chk(R_C2, 16'h000B, "R9 clear bit set");
    chk(R_C2, 16'h0009, "R9 clear bit self-clears");
    chk(R_SUB, 16'h0000, "R9 subsec cleared");
  endtask

  task automatic t_rollover();
    wr(R_C1, 16'h0000, 2'b01);
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 16'h2099);
    ticks(127);
    chk(R_SEC, 16'h0059, "R3 no carry before 128");
    chk(R_C1, 16'h0000, "R6 no flag before carry");
    ticks(1);
    chk(R_SUB, 16'h0000, "R3 subsec wrap");
    chk(R_SEC, 16'h0000, "R4 sec wrap");
    chk(R_MIN, 16'h0000, "R4 min wrap");
    chk(R_HOUR, 16'h0000, "R4 hour wrap");
    chk(R_WDAY, 16'h0000, "R4 wday wrap");
    chk(R_DAY, 16'h0001, "R5 day wrap");
    chk(R_MON, 16'h0001, "R5 mon wrap");
    chk(R_YEAR, 16'h2100, "R5 year bcd carry");
    chk(R_C1, 16'h0080, "R6 flag on carry");
  endtask

  task automatic day_roll(input logic [7:0] d, input logic [7:0] mo,
                          input logic [15:0] y, input logic [7:0] ed,
                          input logic [7:0] em, input string req);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, d, mo, y);
    ticks(128);
    chk(R_DAY, {8'h00, ed}, req);
    chk(R_MON, {8'h00, em}, req);
  endtask

  task automatic t_months();
    day_roll(8'h28, 8'h02, 16'h2024, 8'h29, 8'h02, "R5 leap 2024 28th");
    day_roll(8'h29, 8'h02, 16'h2024, 8'h01, 8'h03, "R5 leap 2024 29th");
    day_roll(8'h28, 8'h02, 16'h2023, 8'h01, 8'h03, "R5 common 2023");
    day_roll(8'h28, 8'h02, 16'h2100, 8'h01, 8'h03, "R5 century 2100");
    day_roll(8'h28, 8'h02, 16'h2000, 8'h29, 8'h02, "R5 century 2000");
    day_roll(8'h30, 8'h04, 16'h2024, 8'h01, 8'h05, "R5 30-day month");
    day_roll(8'h30, 8'h01, 16'h2024, 8'h31, 8'h01, "R5 31-day month");
  endtask

  task automatic t_flag();
    wr(R_C1, 16'h0010, 2'b01);
    chk(R_C1, 16'h0010, "R6 write 0 clears");
    chk_irq(1'b0, "R7 irq low");
    set_time(8'h10, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 16'h2024);
    ticks(128);
    chk(R_C1, 16'h0090, "R6 flag set");
    chk_irq(1'b1, "R7 irq high");
    wr(R_C1, 16'h0090, 2'b01);
    chk(R_C1, 16'h0090, "R6 write 1 keeps");
    wr(R_C1, 16'h0010, 2'b01);
    chk(R_C1, 16'h0010, "R6 cleared");
    chk_irq(1'b0, "R7 irq dropped");
    wr(R_C1, 16'h0000, 2'b01);
    ticks(128);
    chk(R_C1, 16'h0080, "R6 flag without enable");
    chk_irq(1'b0, "R7 irq masked");
  endtask

  task automatic t_adjust();
    set_time(8'h45, 8'h10, 8'h07, 8'h00, 8'h01, 8'h01, 16'h2024);
    wr(R_C2, 16'h000D, 2'b01);
    chk(R_SEC, 16'h0000, "R8 round up sec");
    chk(R_MIN, 16'h0011, "R8 round up min");
    chk(R_C2, 16'h0009, "R8 bit reads 0");
    set_time(8'h29, 8'h10, 8'h07, 8'h00, 8'h01, 8'h01, 16'h2024);
    wr(R_C2, 16'h000D, 2'b01);
    chk(R_SEC, 16'h0000, "R8 round down sec");
    chk(R_MIN, 16'h0010, "R8 round down min");
    set_time(8'h30, 8'h59, 8'h05, 8'h00, 8'h01, 8'h01, 16'h2024);
    wr(R_C2, 16'h000D, 2'b01);
    chk(R_MIN, 16'h0000, "R8 boundary 30 min wrap");
    chk(R_HOUR, 16'h0006, "R8 carry into hour");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_subsec();
    t_rollover();
    t_months();
    t_flag();
    t_adjust();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule